// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers a parameterised number of asynchronous interrupt lines, up to 32. It turns each line into a status bit and merges the pending ones into a single request for the processor. Each line has its own sense setting: low level, high level, rising edge or falling edge. Software sets and clears mask bits by writing ones, and acknowledges edge events by writing ones to a clear register. A separate non-maskable request path is tied to line 0.

Software reaches the block through a generic single-cycle register port. Writes take effect on the clock edge while select and write are high. Read data is combinational from the byte address. Every input passes through a two-stage synchroniser before detection. Configuration bits for lines that are not built cannot be written and read as 0. Software can find the line count by writing all ones to the sense-select register and reading it back.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the mask, status, sense-select, edge-polarity, level-polarity and NMI control registers read 0, and irq_o and nmi_o are 0.
- R2: A write to SET_EN (0x00) sets the mask bits (read at MASK, 0x08) where the data has a 1. A write to CLR_EN (0x04) clears them. Mask bits under 0 data bits keep their value.
- R3: A write to ACK (0x10) clears each edge-mode status bit (read at STAT, 0x0C) under a 1 data bit.
- R4: With sense-select bit 0 (SENSE, 0x14) and edge-polarity bit 1 (EDGE_POL, 0x18), a rising input sets the status bit. The bit is still 0 after the second clock edge that follows the input change and is 1 after the third. A falling input does not set it.
- R5: With sense-select bit 0 and edge-polarity bit 0, a falling input sets the status bit and a rising input does not.
- R6: With sense-select bit 1, the status bit follows the active level: high when level-polarity bit (LEVEL_POL, 0x1C) is 1, low when it is 0. An ACK write does not clear it while the level is active.
- R7: Bits at or above NUM_LINES in SENSE, EDGE_POL, LEVEL_POL and MASK ignore writes and read 0. Writing all ones to SENSE reads back exactly NUM_LINES low-order ones.
- R8: irq_o is 1 exactly when some line has both its status bit and its mask bit set.
- R9: Bit 0 of NMI_CTL (0x24) enables the NMI path, and writing 0 disables it. nmi_o equals status bit 0 AND that enable, whatever mask bit 0 holds.
- R10: When an edge event and an ACK write hit the same line in the same cycle, the status bit ends up 1.
- R11: Reads of the write-only offsets 0x00, 0x04 and 0x10 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access select |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, 0 when no read is selected |
| lines_i | input | NUM_LINES | Asynchronous external interrupt lines |
| irq_o | output | 1 | Combined masked interrupt request |
| nmi_o | output | 1 | Non-maskable request from line 0 |

## Verification
A wrong status bit shows on the STAT readback and, when that line is masked, on irq_o. In edge mode the error persists until an acknowledge. In level mode it lasts only as long as the level. A corrupted edge history or synchroniser stage shows as a status bit that sets one cycle early or late, or on the wrong edge direction. The bench therefore samples status after exactly two and three clock edges. Mask corruption shows at once on irq_o. A stuck NMI enable shows on nmi_o in the cycle after the write.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_SET_EN    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CLR_EN    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MASK      = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT      = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_ACK       = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SENSE     = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_EDGE_POL  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_LEVEL_POL = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_NMI_CTL   = 8'h24;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic sense_we_i,
  input  logic edge_we_i,
  input  logic level_we_i,
  input  logic mask_set_i,
  input  logic mask_clr_i,
  input  logic ack_i,
  input  logic wbit_i,
  output logic sense_o,
  output logic edge_o,
  output logic level_o,
  output logic mask_o,
  output logic status_o
);
  logic sense_q, edge_q, level_q, mask_q, status_q, prev_q;
  logic hit;

  // sense 1 = level, 0 = edge
  always_comb begin
    if (sense_q) hit = level_q ? sync_i : ~sync_i;
    else         hit = edge_q ? (sync_i & ~prev_q) : (~sync_i & prev_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q  <= 1'b0;
      edge_q   <= 1'b0;
      level_q  <= 1'b0;
      mask_q   <= 1'b0;
      status_q <= 1'b0;
      prev_q   <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (sense_we_i) sense_q <= wbit_i;
      if (edge_we_i)  edge_q  <= wbit_i;
      if (level_we_i) level_q <= wbit_i;
      if (mask_set_i && wbit_i)      mask_q <= 1'b1;
      else if (mask_clr_i && wbit_i) mask_q <= 1'b0;
      // level tracks input; edge holds until ack, new event wins
      if (sense_q) status_q <= hit;
      else         status_q <= hit | (status_q & ~(ack_i & wbit_i));
    end
  end

  assign sense_o  = sense_q;
  assign edge_o   = edge_q;
  assign level_o  = level_q;
  assign mask_o   = mask_q;
  assign status_o = status_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_LINES-1:0] lines_i,
  output logic                 irq_o,
  output logic                 nmi_o
);
  logic [NUM_LINES-1:0] sync_s;
  logic [NUM_LINES-1:0] sense_q, edge_q, level_q, mask_q, status_q;
  logic                 nmi_en_q;
  logic                 wr;
  logic                 we_set, we_clr, we_ack, we_sense, we_edge, we_level, we_nmi;
  logic [DATA_W-1:0]    rd;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata_i;

  ext_irq_sync #(.WIDTH(NUM_LINES), .STAGES(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lines_i),
    .q_o   (sync_s)
  );

  assign wr       = sel_i & we_i;
  assign we_set   = wr && (addr_i == OFS_SET_EN);
  assign we_clr   = wr && (addr_i == OFS_CLR_EN);
  assign we_ack   = wr && (addr_i == OFS_ACK);
  assign we_sense = wr && (addr_i == OFS_SENSE);
  assign we_edge  = wr && (addr_i == OFS_EDGE_POL);
  assign we_level = wr && (addr_i == OFS_LEVEL_POL);
  assign we_nmi   = wr && (addr_i == OFS_NMI_CTL);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    ext_irq_line i_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sync_i    (sync_s[i]),
      .sense_we_i(we_sense),
      .edge_we_i (we_edge),
      .level_we_i(we_level),
      .mask_set_i(we_set),
      .mask_clr_i(we_clr),
      .ack_i     (we_ack),
      .wbit_i    (wdata_i[i]),
      .sense_o   (sense_q[i]),
      .edge_o    (edge_q[i]),
      .level_o   (level_q[i]),
      .mask_o    (mask_q[i]),
      .status_o  (status_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     nmi_en_q <= 1'b0;
    else if (we_nmi) nmi_en_q <= wdata_i[0];
  end

  always_comb begin
    unique case (addr_i)
      OFS_MASK:      rd = DATA_W'(mask_q);
      OFS_STAT:      rd = DATA_W'(status_q);
      OFS_SENSE:     rd = DATA_W'(sense_q);
      OFS_EDGE_POL:  rd = DATA_W'(edge_q);
      OFS_LEVEL_POL: rd = DATA_W'(level_q);
      OFS_NMI_CTL:   rd = DATA_W'(nmi_en_q);
      default:       rd = '0;
    endcase
  end

  assign rdata_o = (sel_i && !we_i) ? rd : '0;
  assign irq_o   = |(status_q & mask_q);
  assign nmi_o   = status_q[0] & nmi_en_q;
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sel_i,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic [DATA_W-1:0]    rdata_i,
  input logic                 irq_i,
  input logic                 nmi_i,
  input logic [NUM_LINES-1:0] mask_i,
  input logic [NUM_LINES-1:0] status_i,
  input logic                 nmi_en_i
);
  localparam logic [DATA_W-1:0] LINE_MASK = DATA_W'((64'd1 << NUM_LINES) - 64'd1);

  // R2
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == OFS_SET_EN) |=>
      ((mask_i & $past(wdata_i[NUM_LINES-1:0])) == $past(wdata_i[NUM_LINES-1:0])));

  // R2
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == OFS_CLR_EN) |=>
      ((mask_i & $past(wdata_i[NUM_LINES-1:0])) == '0));

  // R7
  sense_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && addr_i == OFS_SENSE) |-> ((rdata_i & ~LINE_MASK) == '0));

  // R8
  irq_needs_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (|mask_i && |status_i));

  // R9
  nmi_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |-> (status_i[0] && nmi_en_i));

  // R11
  wo_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && (addr_i == OFS_SET_EN || addr_i == OFS_CLR_EN || addr_i == OFS_ACK))
      |-> (rdata_i == '0));
endmodule

bind ext_irq_ctrl ext_irq_chk #(.NUM_LINES(NUM_LINES)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_i (rdata_o),
  .irq_i   (irq_o),
  .nmi_i   (nmi_o),
  .mask_i  (mask_q),
  .status_i(status_q),
  .nmi_en_i(nmi_en_q)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
  import ext_irq_pkg::*;

  localparam int unsigned NUM_LINES  = 8;
  localparam time         CLK_PERIOD = 10ns;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 sel_i = 1'b0;
  logic                 we_i = 1'b0;
  logic [ADDR_W-1:0]    addr_i = '0;
  logic [DATA_W-1:0]    wdata_i = '0;
  logic [DATA_W-1:0]    rdata_o;
  logic [NUM_LINES-1:0] lines = '0;
  logic                 irq_o, nmi_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_ctrl #(.NUM_LINES(NUM_LINES)) i_ext_irq_ctrl (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .lines_i(lines),
    .irq_o  (irq_o),
    .nmi_o  (nmi_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    sel_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    sel_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    sel_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    sel_i = 1'b0;
  endtask

  task automatic expect_reg(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    expect_reg("R1 mask",   OFS_MASK, 0);
    expect_reg("R1 status", OFS_STAT, 0);
    expect_reg("R1 sense",  OFS_SENSE, 0);
    expect_reg("R1 edge",   OFS_EDGE_POL, 0);
    expect_reg("R1 level",  OFS_LEVEL_POL, 0);
    expect_reg("R1 nmi",    OFS_NMI_CTL, 0);
    check("R1 irq_o", 32'(irq_o), 0);
    check("R1 nmi_o", 32'(nmi_o), 0);
    expect_reg("R11 set_en read",  OFS_SET_EN, 0);
    expect_reg("R11 clr_en read",  OFS_CLR_EN, 0);
    expect_reg("R11 ack read",     OFS_ACK, 0);
  endtask

  task automatic t_mask;
    bus_write(OFS_SET_EN, 32'h05);
    expect_reg("R2 set", OFS_MASK, 32'h05);
    bus_write(OFS_SET_EN, 32'h02);
    expect_reg("R2 set keeps others", OFS_MASK, 32'h07);
    bus_write(OFS_CLR_EN, 32'h04);
    expect_reg("R2 clr", OFS_MASK, 32'h03);
    bus_write(OFS_SET_EN, 32'hFFFF_FF00);
    expect_reg("R7 mask upper", OFS_MASK, 32'h03);
    bus_write(OFS_CLR_EN, 32'hFFFF_FFFF);
    expect_reg("R2 clr all", OFS_MASK, 32'h00);
  endtask

  task automatic t_linecount;
    bus_write(OFS_SENSE, 32'hFFFF_FFFF);
    expect_reg("R7 line count", OFS_SENSE, 32'h0000_00FF);
    bus_write(OFS_SENSE, 32'h0);
    bus_write(OFS_EDGE_POL, 32'hFFFF_FFFF);
    expect_reg("R7 edge upper", OFS_EDGE_POL, 32'h0000_00FF);
    bus_write(OFS_EDGE_POL, 32'h0);
    bus_write(OFS_LEVEL_POL, 32'hFFFF_FFFF);
    expect_reg("R7 level upper", OFS_LEVEL_POL, 32'h0000_00FF);
    bus_write(OFS_LEVEL_POL, 32'h0);
    bus_write(OFS_ACK, 32'hFF);
    expect_reg("R3 ack all", OFS_STAT, 0);
  endtask

  task automatic t_rise;
    bus_write(OFS_EDGE_POL, 32'h02);
    lines[1] = 1'b1;
    wait_cyc(2);
    expect_reg("R4 not yet after 2", OFS_STAT, 32'h00);
    wait_cyc(1);
    expect_reg("R4 rise after 3", OFS_STAT, 32'h02);
    bus_write(OFS_ACK, 32'h02);
    expect_reg("R3 ack clears", OFS_STAT, 32'h00);
    lines[1] = 1'b0;
    wait_cyc(4);
    expect_reg("R4 fall ignored", OFS_STAT, 32'h00);
  endtask

  task automatic t_fall;
    lines[2] = 1'b1;
    wait_cyc(4);
    expect_reg("R5 rise ignored", OFS_STAT, 32'h00);
    lines[2] = 1'b0;
    wait_cyc(4);
    expect_reg("R5 fall sets", OFS_STAT, 32'h04);
    bus_write(OFS_ACK, 32'h04);
    expect_reg("R3 ack fall", OFS_STAT, 32'h00);
  endtask

  task automatic t_level;
    bus_write(OFS_LEVEL_POL, 32'h08);
    bus_write(OFS_SENSE, 32'h08);
    wait_cyc(1);
    expect_reg("R6 high inactive", OFS_STAT, 32'h00);
    lines[3] = 1'b1;
    wait_cyc(4);
    expect_reg("R6 high active", OFS_STAT, 32'h08);
    bus_write(OFS_ACK, 32'h08);
    wait_cyc(1);
    expect_reg("R6 ack no effect", OFS_STAT, 32'h08);
    lines[3] = 1'b0;
    wait_cyc(4);
    expect_reg("R6 follows drop", OFS_STAT, 32'h00);
    bus_write(OFS_LEVEL_POL, 32'h00);
    wait_cyc(1);
    expect_reg("R6 low active", OFS_STAT, 32'h08);
    bus_write(OFS_SENSE, 32'h00);
    bus_write(OFS_ACK, 32'h08);
    expect_reg("R3 after level", OFS_STAT, 32'h00);
  endtask

  task automatic t_irq;
    lines[4] = 1'b1;
    wait_cyc(4);
    lines[4] = 1'b0;
    wait_cyc(4);
    check("R8 unmasked quiet", 32'(irq_o), 0);
    bus_write(OFS_SET_EN, 32'h20);
    check("R8 other mask quiet", 32'(irq_o), 0);
    bus_write(OFS_SET_EN, 32'h10);
    check("R8 masked fires", 32'(irq_o), 1);
    bus_write(OFS_ACK, 32'h10);
    check("R8 ack drops", 32'(irq_o), 0);
    bus_write(OFS_CLR_EN, 32'hFF);
  endtask

  task automatic t_nmi;
    lines[0] = 1'b1;
    wait_cyc(4);
    lines[0] = 1'b0;
    wait_cyc(4);
    check("R9 disabled", 32'(nmi_o), 0);
    bus_write(OFS_NMI_CTL, 32'h1);
    check("R9 enabled", 32'(nmi_o), 1);
    check("R9 mask independent irq", 32'(irq_o), 0);
    expect_reg("R9 ctl read", OFS_NMI_CTL, 32'h1);
    bus_write(OFS_NMI_CTL, 32'h0);
    check("R9 disable", 32'(nmi_o), 0);
    bus_write(OFS_ACK, 32'h01);
  endtask

  task automatic t_collide;
    bus_write(OFS_EDGE_POL, 32'h40);
    lines[6] = 1'b1;
    wait_cyc(2);
    bus_write(OFS_ACK, 32'h40);
    expect_reg("R10 set wins", OFS_STAT, 32'h40);
    bus_write(OFS_ACK, 32'h40);
    expect_reg("R3 later ack", OFS_STAT, 32'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_linecount();
    t_rise();
    t_fall();
    t_level();
    t_irq();
    t_nmi();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule